// File: doc/BRIEF.md
# Noise-Normalized Pixel Energy Unit

This block turns one pixel's three most recent samples into an energy figure scaled by that pixel's noise. It squares the three signed samples and adds them. It shifts the total left by eight bits, which multiplies it by 256. It then divides the result by a per-pixel noise variance and drops the remainder. A downstream neighbourhood adder and threshold compare consume the result. The threshold there must carry the same factor of 256.

Software fills the per-pixel variances through a simple write port before the stream starts. The stream then presents at most one sample triple every three clocks, each tagged with its pixel index. Every accepted triple produces exactly one result four clocks later, and that result keeps its pixel index. The first clock forms the sum of squares. The next three clocks run a radix-2 restoring division that settles a third of the quotient bits in each clock.

Top module: `nne_energy_unit`

## Requirements
- R1: A triple accepted on a clock edge (inVld high) yields outVld high for exactly one cycle, four edges later. outEnergy and outIdx keep their values after that pulse until the next result.
- R2: outEnergy equals floor(256 * (a*a + b*b + c*c) / v) for a variance v that is not zero. a, b and c are the samples read as 9-bit two's complement, so a negative sample gives the same energy as its magnitude.
- R3: outEnergy is 26 bits wide and never overflows. Three samples of -256 with a variance of 1 give 50331648.
- R4: A variance of zero gives the all-ones value 67108863, whatever the samples.
- R5: The unit accepts a new triple every third clock. Inputs must be spaced by at least three clocks. At that spacing, results come out in order and each one is correct.
- R6: A variance write (varWrEn high on an edge) affects triples accepted on later edges. A triple for the same pixel accepted on the edge of the write still uses the old variance.
- R7: A variance write to one pixel leaves the variance of every other pixel unchanged.
- R8: While rstN is low, and after reset until a triple is accepted, outVld stays low.
- R9: outIdx equals the inIdx of the triple that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the control state |
| varWrEn | input | 1 | Write strobe for the variance file |
| varWrIdx | input | IDX_W | Pixel whose variance is written |
| varWrData | input | VAR_W | New variance value |
| inVld | input | 1 | A sample triple is present this cycle |
| inIdx | input | IDX_W | Pixel index of the triple |
| sampN | input | SAMPLE_W | Newest sample, signed |
| sampN1 | input | SAMPLE_W | Previous sample, signed |
| sampN2 | input | SAMPLE_W | Oldest sample, signed |
| outVld | output | 1 | Result strobe |
| outIdx | output | IDX_W | Pixel index of the result |
| outEnergy | output | 2*SAMPLE_W+SCALE_SH | Normalized energy |

## Verification
The bench shrinks the variance file to 16 pixels, so the index is 4 bits wide and every entry can be preloaded with a known value. It keeps the default 9-bit samples, 16-bit variances and the shift of eight. That brings the full 26-bit quotient within reach: the -256 corner, the all-ones result for a zero divisor, a divisor of 65535, and truncation at small quotients. The bench also drives triples at the fastest allowed spacing of three clocks, which exercises the hand-off between successive divisions.

// File: rtl/nne_pkg.sv
package nne_pkg;

  // Strobes from control to datapath, one bit per pipeline action.
  typedef struct packed {
    logic sqLoad;    // capture sum of squares and variance
    logic divFirst;  // first division slice, operands from stage one
    logic divNext;   // second or third slice, operands from divider state
    logic divLast;   // third slice, also loads the output registers
  } nneStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MID  = 2'd1,
    PH_LAST = 2'd2
  } nnePhase_t;

endpackage

// File: rtl/nne_varfile.sv
module nne_varfile #(
  parameter int DEPTH = 3072,
  parameter int IDX_W = 12,
  parameter int VAR_W = 16
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VAR_W-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [VAR_W-1:0] rdData
);

  logic [VAR_W-1:0] varMem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) varMem[wrIdx] <= wrData;
  end

  // Asynchronous read: a write on the same edge is seen only afterwards.
  assign rdData = varMem[rdIdx];

endmodule

// File: rtl/nne_ctrl.sv
module nne_ctrl
  import nne_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inVld,
  output nneStrobes_t strobes,
  output logic        outVld
);

  logic      s1Vld;
  nnePhase_t phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Vld  <= 1'b0;
      phase  <= PH_IDLE;
      outVld <= 1'b0;
    end else begin
      s1Vld  <= inVld;
      outVld <= (phase == PH_LAST);
      if (s1Vld)                 phase <= PH_MID;
      else if (phase == PH_MID)  phase <= PH_LAST;
      else                       phase <= PH_IDLE;
    end
  end

  always_comb begin
    strobes.sqLoad   = inVld;
    strobes.divFirst = s1Vld;
    strobes.divNext  = (phase != PH_IDLE);
    strobes.divLast  = (phase == PH_LAST);
  end

endmodule

// File: rtl/nne_datapath.sv
module nne_datapath
  import nne_pkg::*;
#(
  parameter int SAMPLE_W = 9,
  parameter int VAR_W    = 16,
  parameter int IDX_W    = 12,
  parameter int SCALE_SH = 8,
  parameter int SUM_W    = 2 * SAMPLE_W,
  parameter int NUM_W    = SUM_W + SCALE_SH,
  parameter int STEPS    = 3
) (
  input  logic                       clk,
  input  nneStrobes_t                strobes,
  input  logic [IDX_W-1:0]           inIdx,
  input  logic signed [SAMPLE_W-1:0] sampN,
  input  logic signed [SAMPLE_W-1:0] sampN1,
  input  logic signed [SAMPLE_W-1:0] sampN2,
  input  logic [VAR_W-1:0]           rdVar,
  output logic [IDX_W-1:0]           outIdx,
  output logic [NUM_W-1:0]           outEnergy
);

  localparam int SQ_W  = 2 * SAMPLE_W - 1;               // (2^(W-1))^2 fits
  localparam int CHUNK = (NUM_W + STEPS - 1) / STEPS;    // quotient bits per clock
  localparam int PAD_W = CHUNK * STEPS;

  // ---------------- stage one: magnitudes, squares, sum ----------------
  logic signed [SAMPLE_W-1:0] sampArr [3];
  logic [SQ_W-1:0]            sqArr   [3];

  assign sampArr[0] = sampN;
  assign sampArr[1] = sampN1;
  assign sampArr[2] = sampN2;

  for (genvar g = 0; g < 3; g++) begin : g_square
    logic [SAMPLE_W-1:0] mag;
    logic [SQ_W-1:0]     magWide;
    assign mag     = sampArr[g][SAMPLE_W-1] ? (~sampArr[g] + 1'b1) : sampArr[g];
    assign magWide = SQ_W'(mag);
    assign sqArr[g] = magWide * magWide;
  end

  logic [SUM_W-1:0] sumNow;
  assign sumNow = SUM_W'(sqArr[0]) + SUM_W'(sqArr[1]) + SUM_W'(sqArr[2]);

  logic [SUM_W-1:0] s1Sum;
  logic [VAR_W-1:0] s1Var;
  logic [IDX_W-1:0] s1Idx;

  always_ff @(posedge clk) begin
    if (strobes.sqLoad) begin
      s1Sum <= sumNow;
      s1Var <= rdVar;
      s1Idx <= inIdx;
    end
  end

  // ---------------- stage two: three-slice restoring divider ----------------
  logic [PAD_W-1:0] dvdR, quoR;
  logic [VAR_W-1:0] remR, divR;
  logic [IDX_W-1:0] dIdx;

  logic [PAD_W-1:0] dvdSrc, quoSrc, dvdNext, quoNext;
  logic [VAR_W-1:0] remSrc, divSrc, remNext;

  always_comb begin
    if (strobes.divFirst) begin
      dvdSrc = PAD_W'({s1Sum, {SCALE_SH{1'b0}}});
      quoSrc = '0;
      remSrc = '0;
      divSrc = s1Var;
    end else begin
      dvdSrc = dvdR;
      quoSrc = quoR;
      remSrc = remR;
      divSrc = divR;
    end
  end

  always_comb begin
    logic [VAR_W:0]   trial;
    logic [VAR_W-1:0] r;
    logic [PAD_W-1:0] d;
    logic [PAD_W-1:0] q;
    r = remSrc;
    d = dvdSrc;
    q = quoSrc;
    for (int k = 0; k < CHUNK; k++) begin
      trial = {r, d[PAD_W-1]};
      d     = {d[PAD_W-2:0], 1'b0};
      // A zero divisor always passes the compare, so every bit becomes one.
      if (trial >= {1'b0, divSrc}) begin
        trial = trial - {1'b0, divSrc};
        q     = {q[PAD_W-2:0], 1'b1};
      end else begin
        q     = {q[PAD_W-2:0], 1'b0};
      end
      r = trial[VAR_W-1:0];
    end
    remNext = r;
    dvdNext = d;
    quoNext = q;
  end

  always_ff @(posedge clk) begin
    if (strobes.divFirst || strobes.divNext) begin
      dvdR <= dvdNext;
      quoR <= quoNext;
      remR <= remNext;
      divR <= divSrc;
    end
    if (strobes.divFirst) dIdx <= s1Idx;
    if (strobes.divLast) begin
      outEnergy <= NUM_W'(quoNext);
      outIdx    <= dIdx;
    end
  end

endmodule

// File: rtl/nne_energy_unit.sv
module nne_energy_unit
  import nne_pkg::*;
#(
  parameter int PIXELS   = 3072,
  parameter int SAMPLE_W = 9,
  parameter int VAR_W    = 16,
  parameter int SCALE_SH = 8,
  parameter int IDX_W    = $clog2(PIXELS),
  parameter int NUM_W    = 2 * SAMPLE_W + SCALE_SH
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       varWrEn,
  input  logic [IDX_W-1:0]           varWrIdx,
  input  logic [VAR_W-1:0]           varWrData,
  input  logic                       inVld,
  input  logic [IDX_W-1:0]           inIdx,
  input  logic signed [SAMPLE_W-1:0] sampN,
  input  logic signed [SAMPLE_W-1:0] sampN1,
  input  logic signed [SAMPLE_W-1:0] sampN2,
  output logic                       outVld,
  output logic [IDX_W-1:0]           outIdx,
  output logic [NUM_W-1:0]           outEnergy
);

  localparam int SUM_W = 2 * SAMPLE_W;

  nneStrobes_t      strobes;
  logic [VAR_W-1:0] rdVar;

  nne_varfile #(
    .DEPTH (PIXELS),
    .IDX_W (IDX_W),
    .VAR_W (VAR_W)
  ) u_varfile (
    .clk    (clk),
    .wrEn   (varWrEn),
    .wrIdx  (varWrIdx),
    .wrData (varWrData),
    .rdIdx  (inIdx),
    .rdData (rdVar)
  );

  nne_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inVld   (inVld),
    .strobes (strobes),
    .outVld  (outVld)
  );

  nne_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .VAR_W    (VAR_W),
    .IDX_W    (IDX_W),
    .SCALE_SH (SCALE_SH),
    .SUM_W    (SUM_W),
    .NUM_W    (NUM_W),
    .STEPS    (3)
  ) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .inIdx     (inIdx),
    .sampN     (sampN),
    .sampN1    (sampN1),
    .sampN2    (sampN2),
    .rdVar     (rdVar),
    .outIdx    (outIdx),
    .outEnergy (outEnergy)
  );

endmodule

// File: rtl/nne_energy_chk.sv
module nne_energy_chk #(
  parameter int SAMPLE_W = 9,
  parameter int IDX_W    = 12,
  parameter int NUM_W    = 26
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inVld,
  input logic [IDX_W-1:0]           inIdx,
  input logic signed [SAMPLE_W-1:0] sampN,
  input logic signed [SAMPLE_W-1:0] sampN1,
  input logic signed [SAMPLE_W-1:0] sampN2,
  input logic                       outVld,
  input logic [IDX_W-1:0]           outIdx,
  input logic [NUM_W-1:0]           outEnergy
);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inVld |-> ##4 outVld);

  p_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    outVld |=> !outVld);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    outVld |=> ($stable(outEnergy) && $stable(outIdx)));

  p_index_r9: assert property (@(posedge clk) disable iff (!rstN)
    inVld |-> ##4 (outIdx == $past(inIdx, 4)));

  p_spacing1_r5: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> !inVld);

  p_spacing2_r5: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> ##1 !inVld);

  // Zero energy in: result is zero, or all ones for a zero variance (R2, R4).
  p_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && sampN == '0 && sampN1 == '0 && sampN2 == '0)
      |-> ##4 (outEnergy == '0 || outEnergy == '1));

endmodule

bind nne_energy_unit nne_energy_chk #(
  .SAMPLE_W (SAMPLE_W),
  .IDX_W    (IDX_W),
  .NUM_W    (NUM_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inVld     (inVld),
  .inIdx     (inIdx),
  .sampN     (sampN),
  .sampN1    (sampN1),
  .sampN2    (sampN2),
  .outVld    (outVld),
  .outIdx    (outIdx),
  .outEnergy (outEnergy)
);

// File: tb/tb_nne_energy_unit.sv
`timescale 1ns/1ps
module tb_nne_energy_unit;

  localparam int PIXELS   = 16;
  localparam int SAMPLE_W = 9;
  localparam int VAR_W    = 16;
  localparam int SCALE_SH = 8;
  localparam int IDX_W    = 4;
  localparam int NUM_W    = 26;
  localparam longint ALL_ONES = (64'd1 << NUM_W) - 1;

  localparam int NV = 8;
  localparam int T_IDX [NV] = '{0, 1, 2, 3, 7, 15, 9, 4};
  localparam int T_A   [NV] = '{10, -256, 1, 255, 100, -128, 0, -7};
  localparam int T_B   [NV] = '{-20, -256, 0, -1, 100, 64, 0, 13};
  localparam int T_C   [NV] = '{30, -256, 0, 0, -100, -32, 0, 200};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic varWrEn = 1'b0;
  logic [IDX_W-1:0] varWrIdx = '0;
  logic [VAR_W-1:0] varWrData = '0;
  logic inVld = 1'b0;
  logic [IDX_W-1:0] inIdx = '0;
  logic signed [SAMPLE_W-1:0] sampN = '0, sampN1 = '0, sampN2 = '0;
  logic outVld;
  logic [IDX_W-1:0] outIdx;
  logic [NUM_W-1:0] outEnergy;

  always #10 clk = ~clk;

  nne_energy_unit #(
    .PIXELS (PIXELS), .SAMPLE_W (SAMPLE_W), .VAR_W (VAR_W), .SCALE_SH (SCALE_SH)
  ) dut (
    .clk (clk), .rstN (rstN),
    .varWrEn (varWrEn), .varWrIdx (varWrIdx), .varWrData (varWrData),
    .inVld (inVld), .inIdx (inIdx),
    .sampN (sampN), .sampN1 (sampN1), .sampN2 (sampN2),
    .outVld (outVld), .outIdx (outIdx), .outEnergy (outEnergy)
  );

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;
  longint varModel [PIXELS];

  int     expIdx [64];
  longint expVal [64];
  longint expCyc [64];
  string  expReq [64];
  int     expHead = 0;
  int     expTail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint energyOf(int a, int b, int c, longint v);
    if (v == 0) return ALL_ONES;
    return ((longint'(a*a + b*b + c*c)) << SCALE_SH) / v;
  endfunction

  task automatic report(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare each result as it appears (R1 latency, R2 value, R9 index).
  always @(negedge clk) begin
    if (rstN && outVld) begin
      if (expHead >= expTail) begin
        report(1'b0, "R1", "unexpected result", 1, 0);
      end else begin
        report(cyc == expCyc[expHead], "R1", "result cycle", cyc, expCyc[expHead]);
        report(int'(outIdx) == expIdx[expHead], "R9", "result index",
               longint'(outIdx), longint'(expIdx[expHead]));
        report(longint'(outEnergy) == expVal[expHead], expReq[expHead], "energy",
               longint'(outEnergy), expVal[expHead]);
        expHead++;
      end
    end
  end

  task automatic writeVar(int p, longint v);
    @(negedge clk);
    varWrEn = 1'b1; varWrIdx = IDX_W'(p); varWrData = VAR_W'(v);
    @(negedge clk);
    varWrEn = 1'b0;
    varModel[p] = v;
  endtask

  // Drive one triple, then idle two cycles: the fastest allowed spacing.
  task automatic issue(int p, int a, int b, int c, string req, bit wrSame = 1'b0, longint wv = 0);
    @(negedge clk);
    inVld = 1'b1; inIdx = IDX_W'(p);
    sampN = SAMPLE_W'(a); sampN1 = SAMPLE_W'(b); sampN2 = SAMPLE_W'(c);
    expIdx[expTail] = p;
    expVal[expTail] = energyOf(a, b, c, varModel[p]);
    expCyc[expTail] = cyc + 4;
    expReq[expTail] = req;
    expTail++;
    if (wrSame) begin
      varWrEn = 1'b1; varWrIdx = IDX_W'(p); varWrData = VAR_W'(wv);
    end
    @(negedge clk);
    inVld = 1'b0; varWrEn = 1'b0;
    if (wrSame) varModel[p] = wv;
    @(negedge clk);
  endtask

  initial begin
    #(20.0 * 200000);
    report(1'b0, "R1", "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R8: quiet output during and after reset
    repeat (3) @(negedge clk);
    report(outVld == 1'b0, "R8", "outVld in reset", longint'(outVld), 0);
    rstN = 1'b1;
    for (int p = 0; p < PIXELS; p++) writeVar(p, 3 + 5 * p);
    report(outVld == 1'b0, "R8", "outVld idle after reset", longint'(outVld), 0);

    // Table walk at full rate (R2, R3, R5)
    for (int i = 0; i < NV; i++) issue(T_IDX[i], T_A[i], T_B[i], T_C[i], "R5");

    // R2: sign symmetry and truncation
    issue(2, -1, 0, 0, "R2");
    writeVar(11, 3);
    issue(11, 1, 0, 0, "R2");
    writeVar(8, 65535);
    issue(8, 1, 0, 0, "R2");

    // R3: largest magnitude with unit variance
    writeVar(10, 1);
    issue(10, -256, -256, -256, "R3");

    // R4: zero variance saturates
    writeVar(6, 0);
    issue(6, 1, 2, 3, "R4");
    issue(6, 0, 0, 0, "R4");

    // R6: write on the same edge as a sample uses the old variance, later ones the new
    issue(12, 50, 50, 50, "R6", 1'b1, 1000);
    issue(12, 50, 50, 50, "R6");

    // R7: a write to pixel 13 leaves pixel 14 alone
    writeVar(13, 7);
    issue(14, 20, 30, 40, "R7");
    issue(13, 20, 30, 40, "R7");

    repeat (8) @(negedge clk);
    report(expHead == expTail, "R1", "results outstanding",
           longint'(expTail - expHead), 0);
    report(outVld == 1'b0, "R1", "outVld quiet at end", longint'(outVld), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule